// File: doc/BRIEF.md
# Boot Strap Memory Remap Decoder

This block sits between a processor's read bus and two on-chip memories: a user flash bank and a system boot bank. Every accepted read is decoded and sent to one bank, or flagged as a bus error when it lands outside every mapped window. Each bank keeps a fixed direct window. A low window starting at address zero aliases one of the two banks, so the processor's reset fetch can be steered without changing its code.

The alias target depends on two things. The first is a strap pin captured while reset is held. The second is a one-time blank check that reads word zero of user flash right after reset. An erased flash, where the erased value is a build-time choice between all ones and all zeros, forces the alias onto the system bank whatever the strap says. Upstream is a valid/ready read request carrying a tag. The response comes back one cycle later with the same tag. Both memory ports have a one-cycle read latency.

Top module: `boot_remap_decoder`

## Requirements
- R1: Addresses 0x0800_0000 to 0x08FF_FFFF read user flash word addr[FLASH_AW+1:2].
- R2: Addresses 0x0900_0000 to 0x09FF_FFFF (bit 24 set in the direct region) read system bank word addr[SYS_AW+1:2].
- R3: Addresses 0x0000_0000 to 0x00FF_FFFF (alias window) return the same flash words as the direct flash window when the latched strap is 0 and flash is not blank.
- R4: With the latched strap at 1, the alias window reads the system bank, and the direct flash window still reads flash.
- R5: The strap is captured at every rising edge while rst_n is low and holds its last captured value until the next reset. Changes after reset do not move the alias.
- R6: With BLANK_ONES=1, a flash word 0 of 0xFFFF_FFFF marks flash blank, and the alias then reads the system bank even with the strap at 0.
- R7: With BLANK_ONES=0, a flash word 0 of 0x0000_0000 marks flash blank. An all-ones word 0 is not blank in that variant.
- R8: req_ready and resp_valid are 0 during reset. req_ready stays 0 for the first rising edge after reset release and goes to 1 after the second, once the blank check has read flash word 0.
- R9: A request accepted at a rising edge gives resp_valid at the next edge, with resp_tag equal to the request tag. Back-to-back requests give one response per cycle in issue order.
- R10: An address outside every window (for example 0x0100_0000, 0x0A00_0000, 0xFFFF_FFFC) responds with resp_err=1 and resp_data=0. Mapped reads have resp_err=0.
- R11: Address bits above the bank's word index and the two byte-offset bits are ignored. For example, 0x0000_0100 reads flash word 0 with 64 flash words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Boot select strap: 0 user flash, 1 system bank |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | 32 | Byte address |
| req_tag | input | TAG_W | Request tag |
| resp_valid | output | 1 | Response valid |
| resp_data | output | DATA_W | Read data, zero on error |
| resp_err | output | 1 | Unmapped address |
| resp_tag | output | TAG_W | Tag of the answered request |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_rd_addr | output | FLASH_AW | Flash word index |
| fl_rd_data | input | DATA_W | Flash data, one cycle after strobe |
| sys_rd_en | output | 1 | System bank read strobe |
| sys_rd_addr | output | SYS_AW | System bank word index |
| sys_rd_data | input | DATA_W | System bank data, one cycle after strobe |

## Verification
The bench runs two instances side by side, one per blank polarity, against the same memory contents. An inverted polarity or a missing blank check then shows up as one instance's alias landing in the wrong bank. It changes the strap after reset, so a design that tracks the live pin instead of the latched value would move the alias mid-run. It also probes addresses just past a bank's size and in the gap between windows: a decoder without masking, or one that wrongly matches only the top byte, would return the wrong word or no error. Back-to-back tagged reads and an exact count of the ready delay after reset catch a response pipeline that is off by one cycle, or a bus that opens before the blank check has finished.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_SYS   = 2'd2
  } target_e;

  // Region codes on the upper address bits
  localparam logic [7:0] ALIAS_HI  = 8'h00;  // addr[31:24]
  localparam logic [6:0] DIRECT_HI = 7'h04;  // addr[31:25]; bit 24 picks the bank

  function automatic target_e classify(input logic [ADDR_W-1:0] a, input logic alias_sys);
    target_e t;
    if (a[31:24] == ALIAS_HI)
      t = alias_sys ? TGT_SYS : TGT_FLASH;
    else if (a[31:25] == DIRECT_HI)
      t = a[24] ? TGT_SYS : TGT_FLASH;
    else
      t = TGT_NONE;
    return t;
  endfunction

  function automatic logic in_alias(input logic [ADDR_W-1:0] a);
    return a[31:24] == ALIAS_HI;
  endfunction

endpackage

// File: rtl/boot_strap_ctl.sv
module boot_strap_ctl #(
  parameter int   DATA_W     = 32,
  parameter logic BLANK_ONES = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_pin,
  input  logic [DATA_W-1:0] flash_word0,
  output logic              chk_rd_en,
  output logic              strap_q,
  output logic              blank_q,
  output logic              ready
);

  typedef enum logic [1:0] {ST_ISSUE, ST_WAIT, ST_RUN} st_e;
  st_e st;

  logic chk_capture;

  function automatic logic word_is_blank(input logic [DATA_W-1:0] w);
    return BLANK_ONES ? (&w) : ~(|w);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_ISSUE;
      strap_q <= strap_pin;
      blank_q <= 1'b0;
    end else begin
      case (st)
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          blank_q <= word_is_blank(flash_word0);
          st      <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign chk_rd_en   = rst_n && (st == ST_ISSUE);
  assign chk_capture = (st == ST_WAIT);
  assign ready       = rst_n && (st == ST_RUN);

  // R5: the latched strap never moves between resets
  a_r5_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

  // R8: the bus opens only after the blank word was captured
  a_r8_ready_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(chk_capture));

  // R8: blank flag settles before the bus opens and stays put
  a_r8_blank_stable_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ready && $past(ready) |-> $stable(blank_q));

endmodule

// File: rtl/remap_addr_decode.sv
module remap_addr_decode
  import boot_remap_pkg::*;
#(
  parameter int FLASH_AW = 6,
  parameter int SYS_AW   = 5
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                alias_sys,
  output target_e             target,
  output logic [FLASH_AW-1:0] fl_idx,
  output logic [SYS_AW-1:0]   sys_idx
);

  always_comb begin
    target  = classify(addr, alias_sys);
    fl_idx  = addr[FLASH_AW+1:2];
    sys_idx = addr[SYS_AW+1:2];
  end

endmodule

// File: rtl/remap_resp_path.sv
module remap_resp_path
  import boot_remap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  target_e           target,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DATA_W-1:0] fl_data,
  input  logic [DATA_W-1:0] sys_data,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_err,
  output logic [TAG_W-1:0]  resp_tag
);

  target_e route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      route_q    <= TGT_NONE;
      resp_tag   <= '0;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        route_q  <= target;
        resp_tag <= tag;
      end
    end
  end

  always_comb begin
    resp_err  = resp_valid && (route_q == TGT_NONE);
    resp_data = '0;
    if (resp_valid) begin
      case (route_q)
        TGT_FLASH: resp_data = fl_data;
        TGT_SYS:   resp_data = sys_data;
        default:   resp_data = '0;
      endcase
    end
  end

  // R9: exactly one response for each acceptance, one cycle later
  a_r9_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
  a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !resp_valid);
  // R9: tag travels with its response
  a_r9_tag_forward: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_tag == $past(tag));
  // R10: an error response carries zero data
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_data == '0);

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int   DATA_W     = 32,
  parameter int   TAG_W      = 4,
  parameter int   FLASH_AW   = 6,
  parameter int   SYS_AW     = 5,
  parameter logic BLANK_ONES = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_strap,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_addr,
  input  logic [TAG_W-1:0]    req_tag,
  output logic                resp_valid,
  output logic [DATA_W-1:0]   resp_data,
  output logic                resp_err,
  output logic [TAG_W-1:0]    resp_tag,
  output logic                fl_rd_en,
  output logic [FLASH_AW-1:0] fl_rd_addr,
  input  logic [DATA_W-1:0]   fl_rd_data,
  output logic                sys_rd_en,
  output logic [SYS_AW-1:0]   sys_rd_addr,
  input  logic [DATA_W-1:0]   sys_rd_data
);

  logic                chk_rd_en, strap_q, blank_q, alias_sys, accept;
  target_e             tgt;
  logic [FLASH_AW-1:0] fl_idx;
  logic [SYS_AW-1:0]   sys_idx;

  boot_strap_ctl #(.DATA_W(DATA_W), .BLANK_ONES(BLANK_ONES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_pin  (boot_strap),
    .flash_word0(fl_rd_data),
    .chk_rd_en  (chk_rd_en),
    .strap_q    (strap_q),
    .blank_q    (blank_q),
    .ready      (req_ready)
  );

  assign alias_sys = strap_q | blank_q;
  assign accept    = req_valid & req_ready;

  remap_addr_decode #(.FLASH_AW(FLASH_AW), .SYS_AW(SYS_AW)) u_dec (
    .addr     (req_addr),
    .alias_sys(alias_sys),
    .target   (tgt),
    .fl_idx   (fl_idx),
    .sys_idx  (sys_idx)
  );

  assign fl_rd_en    = chk_rd_en | (accept && tgt == TGT_FLASH);
  assign fl_rd_addr  = chk_rd_en ? '0 : fl_idx;
  assign sys_rd_en   = accept && tgt == TGT_SYS;
  assign sys_rd_addr = sys_idx;

  remap_resp_path #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .target    (tgt),
    .tag       (req_tag),
    .fl_data   (fl_rd_data),
    .sys_data  (sys_rd_data),
    .resp_valid(resp_valid),
    .resp_data (resp_data),
    .resp_err  (resp_err),
    .resp_tag  (resp_tag)
  );

  // R1/R2: at most one bank strobed in a cycle
  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_rd_en, sys_rd_en}));
  // R3: alias goes to flash when strap is low and flash holds code
  a_r3_alias_to_flash: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_alias(req_addr) && !strap_q && !blank_q |-> fl_rd_en && !sys_rd_en);
  // R4: a high strap sends the alias to the system bank
  a_r4_alias_to_sys: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_alias(req_addr) && strap_q |-> sys_rd_en);
  // R6: blank flash steers the alias away from flash
  a_r6_blank_to_sys: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_alias(req_addr) && blank_q |-> !fl_rd_en);
  // R8: no request reaches a bank while the blank check runs
  a_r8_check_private: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rd_en |-> !sys_rd_en && !req_ready);

endmodule

// File: tb/boot_remap_decoder_bench.sv
module boot_remap_decoder_bench;

  localparam int DATA_W = 32, TAG_W = 4, FLASH_AW = 6, SYS_AW = 5;
  localparam int FL_WORDS = 1 << FLASH_AW;
  localparam int SY_WORDS = 1 << SYS_AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, strap = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [TAG_W-1:0] req_tag = '0;

  logic [DATA_W-1:0] flash_mem [FL_WORDS];
  logic [DATA_W-1:0] sys_mem   [SY_WORDS];

  // instance with erased = all ones (a) and erased = all zeros (z)
  logic rdy_a, rv_a, err_a, fe_a, se_a, rdy_z, rv_z, err_z, fe_z, se_z;
  logic [DATA_W-1:0] rd_a, rd_z, fq_a, sq_a, fq_z, sq_z;
  logic [TAG_W-1:0] rt_a, rt_z;
  logic [FLASH_AW-1:0] fa_a, fa_z;
  logic [SYS_AW-1:0] sa_a, sa_z;

  boot_remap_decoder #(.BLANK_ONES(1'b1)) u_boot_remap_decoder (
    .clk(clk), .rst_n(rst_n), .boot_strap(strap),
    .req_valid(req_valid), .req_ready(rdy_a), .req_addr(req_addr), .req_tag(req_tag),
    .resp_valid(rv_a), .resp_data(rd_a), .resp_err(err_a), .resp_tag(rt_a),
    .fl_rd_en(fe_a), .fl_rd_addr(fa_a), .fl_rd_data(fq_a),
    .sys_rd_en(se_a), .sys_rd_addr(sa_a), .sys_rd_data(sq_a));

  boot_remap_decoder #(.BLANK_ONES(1'b0)) u_boot_remap_decoder_z (
    .clk(clk), .rst_n(rst_n), .boot_strap(strap),
    .req_valid(req_valid), .req_ready(rdy_z), .req_addr(req_addr), .req_tag(req_tag),
    .resp_valid(rv_z), .resp_data(rd_z), .resp_err(err_z), .resp_tag(rt_z),
    .fl_rd_en(fe_z), .fl_rd_addr(fa_z), .fl_rd_data(fq_z),
    .sys_rd_en(se_z), .sys_rd_addr(sa_z), .sys_rd_data(sq_z));

  always_ff @(posedge clk) begin
    if (fe_a) fq_a <= flash_mem[fa_a];
    if (se_a) sq_a <= sys_mem[sa_a];
    if (fe_z) fq_z <= flash_mem[fa_z];
    if (se_z) sq_z <= sys_mem[sa_z];
  end

  int checks = 0, errors = 0;

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // expected {err, data} from the address map in the requirements
  function automatic logic [32:0] expect_rd(input logic [31:0] a, input bit alias_sys);
    int fi, si;
    fi = (a >> 2) % FL_WORDS;
    si = (a >> 2) % SY_WORDS;
    if (a < 32'h0100_0000) return alias_sys ? {1'b0, sys_mem[si]} : {1'b0, flash_mem[fi]};
    if (a >= 32'h0800_0000 && a < 32'h0900_0000) return {1'b0, flash_mem[fi]};
    if (a >= 32'h0900_0000 && a < 32'h0A00_0000) return {1'b0, sys_mem[si]};
    return {1'b1, 32'h0};
  endfunction

  task automatic check_resp(input string rq, input logic [31:0] a, input logic [TAG_W-1:0] t,
                            input bit as_a, input bit as_z);
    logic [32:0] ea, ez;
    ea = expect_rd(a, as_a);
    ez = expect_rd(a, as_z);
    check({rq, " valid"}, {63'b0, rv_a & rv_z}, 64'd1);
    check({rq, " tag"}, {56'b0, rt_a, rt_z}, {56'b0, t, t});
    check({rq, " data/err ones-variant"}, {31'b0, err_a, rd_a}, {31'b0, ea});
    check({rq, " data/err zeros-variant"}, {31'b0, err_z, rd_z}, {31'b0, ez});
  endtask

  task automatic read_one(input string rq, input logic [31:0] a, input logic [TAG_W-1:0] t,
                          input bit as_a, input bit as_z);
    req_valid = 1'b1; req_addr = a; req_tag = t;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check_resp(rq, a, t, as_a, as_z);
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    check("R8 ready low in reset", {62'b0, rdy_a, rdy_z}, 64'd0);
    check("R8 resp_valid low in reset", {62'b0, rv_a, rv_z}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready low during blank check", {62'b0, rdy_a, rdy_z}, 64'd0);
    @(negedge clk);
    check("R8 ready high after blank check", {62'b0, rdy_a, rdy_z}, 64'd3);
  endtask

  task automatic t_flash_alias();
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) begin
      read_one("R3 alias reads flash", 32'h0000_0000 + 4*k, 4'(k), 1'b0, 1'b0);
      read_one("R1 direct flash", 32'h0800_0000 + 4*k, 4'(k + 4), 1'b0, 1'b0);
    end
  endtask

  task automatic t_direct_sys();
    for (int k = 0; k < 3; k++)
      read_one("R2 direct system bank", 32'h0900_0000 + 4*k + 8, 4'(k), 1'b0, 1'b0);
  endtask

  task automatic t_masking();
    read_one("R11 alias wraps past flash size", 32'h0000_0100, 4'h1, 1'b0, 1'b0);
    read_one("R11 byte offset ignored", 32'h0800_0107, 4'h2, 1'b0, 1'b0);
    read_one("R11 system index wraps", 32'h0900_0084, 4'h3, 1'b0, 1'b0);
  endtask

  task automatic t_unmapped();
    read_one("R10 gap above alias", 32'h0100_0000, 4'h5, 1'b0, 1'b0);
    read_one("R10 past system window", 32'h0A00_0000, 4'h6, 1'b0, 1'b0);
    read_one("R10 top of space", 32'hFFFF_FFFC, 4'h7, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] al [5];
    al = '{32'h0000_0004, 32'h0900_0000, 32'h0200_0000, 32'h0800_000C, 32'h0000_0008};
    for (int i = 0; i < 5; i++) begin
      req_valid = 1'b1; req_addr = al[i]; req_tag = 4'(9 + i);
      @(posedge clk); @(negedge clk);
      check_resp("R9 back-to-back", al[i], 4'(9 + i), 1'b0, 1'b0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 no response when idle", {62'b0, rv_a, rv_z}, 64'd0);
  endtask

  task automatic t_strap_sys();
    do_reset(1'b1);
    read_one("R4 alias reads system bank", 32'h0000_0004, 4'h1, 1'b1, 1'b1);
    read_one("R4 direct flash unchanged", 32'h0800_0004, 4'h2, 1'b1, 1'b1);
  endtask

  task automatic t_strap_change();
    strap = 1'b0;
    repeat (3) @(negedge clk);
    read_one("R5 strap change after reset ignored", 32'h0000_000C, 4'h3, 1'b1, 1'b1);
    do_reset(1'b0);
    read_one("R5 new reset takes new strap", 32'h0000_000C, 4'h4, 1'b0, 1'b0);
  endtask

  task automatic t_blank_ones();
    flash_mem[0] = 32'hFFFF_FFFF;
    do_reset(1'b0);
    read_one("R6 all-ones flash steers alias to system", 32'h0000_0004, 4'h1, 1'b1, 1'b0);
    read_one("R7 all-ones not blank in zeros variant", 32'h0000_0000, 4'h2, 1'b1, 1'b0);
    read_one("R6 direct flash still readable", 32'h0800_0000, 4'h3, 1'b1, 1'b0);
  endtask

  task automatic t_blank_zeros();
    flash_mem[0] = 32'h0000_0000;
    do_reset(1'b0);
    read_one("R7 all-zeros flash steers alias in zeros variant", 32'h0000_0008, 4'h4, 1'b0, 1'b1);
    flash_mem[0] = 32'hF000_0000;
  endtask

  initial begin
    for (int i = 0; i < FL_WORDS; i++) flash_mem[i] = 32'hF000_0000 | i;
    for (int i = 0; i < SY_WORDS; i++) sys_mem[i]   = 32'h5A00_0000 | i;
    @(negedge clk);
    t_flash_alias();
    t_direct_sys();
    t_masking();
    t_unmapped();
    t_back_to_back();
    t_strap_sys();
    t_strap_change();
    t_blank_ones();
    t_blank_zeros();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule